// File: doc/BRIEF.md
# Ring Buffer Fill Level Tracker

This block keeps the fill level of a byte ring whose length is programmed at run time, anywhere from 1 to 65535 bytes. It holds two 17-bit pointers, a producer (write) pointer and a consumer (read) pointer. Each is a 16-bit byte offset with an extra lap flag above it. When a pointer steps onto the programmed length, its offset goes back to zero and its lap flag flips. Because of this flag, a completely full ring and a completely empty ring can be told apart even when the length is not a power of two.

One end of the ring belongs to hardware and the other to software. In transmit mode the byte mover drains the ring, so its advance strobe moves the read pointer, and software commits new bytes by loading the write pointer. In receive mode the byte mover fills the ring, so its strobe moves the write pointer, and software hands consumed bytes back by loading the read pointer (usually with the write pointer's value). The block reports how many bytes are in the ring, how much room remains, whether the ring is empty or full, and an interrupt request whose condition depends on the direction.

All outputs come combinationally from the pointer registers and the configuration inputs. A pointer load or an accepted advance therefore shows on every output in the cycle after the clock edge that takes it.

Top module: `ring_fill_tracker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both pointers read 0, `valid_size` is 0, `left_size` equals `cfg_len`, `ring_empty` is 1 and `ring_full` is 0.
- R2: A pointer value holds its offset in bits [15:0] and its lap flag in bit 16. An accepted advance adds one to the offset. When the result equals `cfg_len`, the offset becomes 0 and bit 16 inverts instead.
- R3: With `cfg_dir` = 1 (transmit), `hw_adv` moves the read pointer and `sw_ptr_we` loads `sw_ptr_val` into the write pointer. With `cfg_dir` = 0 (receive), `hw_adv` moves the write pointer and `sw_ptr_we` loads the read pointer. A loaded value is visible one cycle later, and the other pointer does not change because of the load.
- R4: `valid_size` equals the write offset minus the read offset, plus `cfg_len` when the two lap flags differ.
- R5: `left_size` equals `cfg_len` minus `valid_size`, so the two always add up to `cfg_len`. A full ring shows `left_size` = 0.
- R6: `ring_empty` is 1 exactly when the two pointers are identical in all 17 bits. `ring_full` is 1 exactly when the offsets match and the lap flags differ. The two are never 1 together.
- R7: `hw_adv` is ignored, and no pointer changes because of it, when the ring is full in receive mode, when it is empty in transmit mode, or when `cfg_len` is 0.
- R8: In receive mode `thr_irq` is 1 exactly when `valid_size` >= `cfg_thresh`. In transmit mode it is 1 exactly when `left_size` >= `cfg_thresh`. So a transmit threshold equal to the length raises the request only once the ring has fully drained.
- R9: A software load and an accepted hardware advance in the same cycle both take effect, each on its own pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 16 | Ring length in bytes |
| cfg_thresh | input | 16 | Interrupt threshold in bytes |
| cfg_dir | input | 1 | 1 = transmit, 0 = receive |
| sw_ptr_we | input | 1 | Software loads the software-owned pointer |
| sw_ptr_val | input | 17 | Pointer value to load (bit 16 is the lap flag) |
| hw_adv | input | 1 | Byte mover moved one byte |
| rd_ptr_o | output | 17 | Current read pointer |
| wr_ptr_o | output | 17 | Current write pointer |
| valid_size | output | 16 | Bytes held in the ring |
| left_size | output | 16 | Free bytes in the ring |
| ring_empty | output | 1 | Ring holds no data |
| ring_full | output | 1 | Ring has no free space |
| thr_irq | output | 1 | Threshold interrupt request |

## Verification
The bench steers toward the wrap boundaries: a one-byte ring, where every accepted advance is also a wrap, and a 65535-byte ring with large software jumps across the seam. A design that compared the offset before incrementing it, or forgot to flip the lap flag, would report a full ring as empty and return a wrong `valid_size`. Strobes are also sent into a full receive ring, an empty transmit ring and a zero-length ring; a design without the guard would let one pointer pass the other, and `valid_size` would jump by the ring length. Software loads that coincide with hardware advances, and a transmit threshold equal to the length, expose a design that lets one pointer update win over the other or that raises the request before the ring has drained.

// File: rtl/ring_fill_pkg.sv
package ring_fill_pkg;

    // Byte offset width; the lap flag sits directly above it.
    localparam int RING_OFS_W = 16;
    localparam int RING_PTR_W = RING_OFS_W + 1;
    localparam int RING_NPTR  = 2;

    typedef logic [RING_OFS_W-1:0] ring_ofs_t;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } ring_dir_e;

    // Index of each pointer in the pointer array.
    localparam int IDX_RD = 0;
    localparam int IDX_WR = 1;

    typedef struct packed {
        logic      lap;
        ring_ofs_t ofs;
    } ring_ptr_t;

    // One-byte step with lap toggle at the programmed length.
    function automatic ring_ptr_t ring_step(ring_ptr_t p, ring_ofs_t len);
        logic [RING_OFS_W:0] nxt;
        ring_ptr_t           r;
        nxt = {1'b0, p.ofs} + {{RING_OFS_W{1'b0}}, 1'b1};
        if (nxt == {1'b0, len}) begin
            r.lap = ~p.lap;
            r.ofs = '0;
        end else begin
            r.lap = p.lap;
            r.ofs = nxt[RING_OFS_W-1:0];
        end
        return r;
    endfunction

    // Bytes between consumer and producer.
    function automatic ring_ofs_t ring_fill(ring_ptr_t wr, ring_ptr_t rd, ring_ofs_t len);
        logic [RING_OFS_W:0] d;
        d = {1'b0, wr.ofs} - {1'b0, rd.ofs};
        if (wr.lap != rd.lap) begin
            d = d + {1'b0, len};
        end
        return d[RING_OFS_W-1:0];
    endfunction

    // Which pointer the byte mover owns in a given direction.
    function automatic int hw_owned_idx(ring_dir_e dir);
        return (dir == DIR_TX) ? IDX_RD : IDX_WR;
    endfunction

endpackage

// File: rtl/ring_ptr.sv
module ring_ptr
    import ring_fill_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ring_ofs_t len,
    input  logic      adv,
    input  logic      ld,
    input  ring_ptr_t ld_val,
    output ring_ptr_t q
);

    ring_ptr_t q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (ld) begin
            q_r <= ld_val;
        end else if (adv) begin
            q_r <= ring_step(q_r, len);
        end
    end

    assign q = q_r;

endmodule

// File: rtl/ring_level.sv
module ring_level
    import ring_fill_pkg::*;
(
    input  ring_ptr_t wr,
    input  ring_ptr_t rd,
    input  ring_ofs_t len,
    output ring_ofs_t fill,
    output ring_ofs_t room,
    output logic      empty,
    output logic      full
);

    logic same_ofs;

    always_comb begin
        same_ofs = (wr.ofs == rd.ofs);
        empty    = same_ofs && (wr.lap == rd.lap);
        full     = same_ofs && (wr.lap != rd.lap);
        fill     = ring_fill(wr, rd, len);
        room     = len - fill;
    end

endmodule

// File: rtl/ring_irq.sv
module ring_irq
    import ring_fill_pkg::*;
(
    input  ring_dir_e dir,
    input  ring_ofs_t fill,
    input  ring_ofs_t room,
    input  ring_ofs_t thresh,
    output logic      irq
);

    ring_ofs_t level;

    always_comb begin
        // Receive watches data, transmit watches space.
        level = (dir == DIR_RX) ? fill : room;
        irq   = (level >= thresh);
    end

endmodule

// File: rtl/ring_fill_tracker.sv
module ring_fill_tracker
    import ring_fill_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [RING_OFS_W-1:0] cfg_len,
    input  logic [RING_OFS_W-1:0] cfg_thresh,
    input  logic                  cfg_dir,
    input  logic                  sw_ptr_we,
    input  logic [RING_PTR_W-1:0] sw_ptr_val,
    input  logic                  hw_adv,
    output logic [RING_PTR_W-1:0] rd_ptr_o,
    output logic [RING_PTR_W-1:0] wr_ptr_o,
    output logic [RING_OFS_W-1:0] valid_size,
    output logic [RING_OFS_W-1:0] left_size,
    output logic                  ring_empty,
    output logic                  ring_full,
    output logic                  thr_irq
);

    ring_dir_e dir;
    ring_ptr_t ptr_q [RING_NPTR];
    ring_ptr_t ld_val;
    ring_ofs_t fill;
    ring_ofs_t room;
    logic      empty;
    logic      full;
    logic      blocked;
    logic      adv_ok;
    int        hw_idx;

    assign dir    = ring_dir_e'(cfg_dir);
    assign ld_val = ring_ptr_t'(sw_ptr_val);
    assign hw_idx = hw_owned_idx(dir);

    // Guard: the moving pointer may never pass the other one.
    always_comb begin
        blocked = (dir == DIR_RX) ? full : empty;
        adv_ok  = hw_adv && !blocked && (cfg_len != '0);
    end

    for (genvar g = 0; g < RING_NPTR; g++) begin : g_ptr
        logic adv_g;
        logic ld_g;
        assign adv_g = adv_ok && (hw_idx == g);
        assign ld_g  = sw_ptr_we && (hw_idx != g);
        ring_ptr u_ptr (
            .clk    (clk),
            .rst    (rst),
            .len    (cfg_len),
            .adv    (adv_g),
            .ld     (ld_g),
            .ld_val (ld_val),
            .q      (ptr_q[g])
        );
    end

    ring_level u_level (
        .wr    (ptr_q[IDX_WR]),
        .rd    (ptr_q[IDX_RD]),
        .len   (cfg_len),
        .fill  (fill),
        .room  (room),
        .empty (empty),
        .full  (full)
    );

    ring_irq u_irq (
        .dir    (dir),
        .fill   (fill),
        .room   (room),
        .thresh (cfg_thresh),
        .irq    (thr_irq)
    );

    assign rd_ptr_o   = ptr_q[IDX_RD];
    assign wr_ptr_o   = ptr_q[IDX_WR];
    assign valid_size = fill;
    assign left_size  = room;
    assign ring_empty = empty;
    assign ring_full  = full;

endmodule

// File: rtl/ring_fill_checker.sv
module ring_fill_checker
    import ring_fill_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [RING_OFS_W-1:0] cfg_len,
    input logic [RING_OFS_W-1:0] cfg_thresh,
    input logic                  cfg_dir,
    input logic                  sw_ptr_we,
    input logic                  hw_adv,
    input logic [RING_PTR_W-1:0] rd_ptr_o,
    input logic [RING_PTR_W-1:0] wr_ptr_o,
    input logic [RING_OFS_W-1:0] valid_size,
    input logic [RING_OFS_W-1:0] left_size,
    input logic                  ring_empty,
    input logic                  ring_full,
    input logic                  thr_irq
);

    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ring_empty && ring_full)); // R6

    AST_EMPTY_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        ring_empty |-> (valid_size == '0)); // R4

    AST_FULL_NO_SPACE: assert property (@(posedge clk) disable iff (rst)
        ring_full |-> (left_size == '0)); // R5

    AST_NO_OVERRUN_RX: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dir && ring_full && hw_adv) |=> $stable(wr_ptr_o)); // R7

    AST_NO_UNDERRUN_TX: assert property (@(posedge clk) disable iff (rst)
        (cfg_dir && ring_empty && hw_adv) |=> $stable(rd_ptr_o)); // R7

    AST_RX_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dir && hw_adv && !ring_full && cfg_len != '0) |=> (wr_ptr_o != $past(wr_ptr_o))); // R2

    AST_TX_RD_OWNED_BY_HW: assert property (@(posedge clk) disable iff (rst)
        (cfg_dir && !hw_adv) |=> $stable(rd_ptr_o)); // R3

    AST_RX_WR_OWNED_BY_HW: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dir && !hw_adv && sw_ptr_we) |=> $stable(wr_ptr_o)); // R3

    AST_RX_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dir && ring_empty && cfg_thresh != '0) |-> !thr_irq); // R8

endmodule

bind ring_fill_tracker ring_fill_checker u_ring_fill_checker (
    .clk        (clk),
    .rst        (rst),
    .cfg_len    (cfg_len),
    .cfg_thresh (cfg_thresh),
    .cfg_dir    (cfg_dir),
    .sw_ptr_we  (sw_ptr_we),
    .hw_adv     (hw_adv),
    .rd_ptr_o   (rd_ptr_o),
    .wr_ptr_o   (wr_ptr_o),
    .valid_size (valid_size),
    .left_size  (left_size),
    .ring_empty (ring_empty),
    .ring_full  (ring_full),
    .thr_irq    (thr_irq)
);

// File: tb/ring_fill_tracker_bench.sv
module ring_fill_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_len = 16'd8;
    logic [15:0] cfg_thresh = 16'd0;
    logic        cfg_dir = 1'b0;
    logic        sw_ptr_we = 1'b0;
    logic [16:0] sw_ptr_val = '0;
    logic        hw_adv = 1'b0;
    logic [16:0] rd_ptr_o;
    logic [16:0] wr_ptr_o;
    logic [15:0] valid_size;
    logic [15:0] left_size;
    logic        ring_empty;
    logic        ring_full;
    logic        thr_irq;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;
    int  m_rd  = 0;
    int  m_wr  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_fill_tracker u_ring_fill_tracker (
        .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_thresh(cfg_thresh),
        .cfg_dir(cfg_dir), .sw_ptr_we(sw_ptr_we), .sw_ptr_val(sw_ptr_val),
        .hw_adv(hw_adv), .rd_ptr_o(rd_ptr_o), .wr_ptr_o(wr_ptr_o),
        .valid_size(valid_size), .left_size(left_size),
        .ring_empty(ring_empty), .ring_full(ring_full), .thr_irq(thr_irq)
    );

    function automatic int p_ofs(int p);  return p & 32'hFFFF; endfunction
    function automatic int p_lap(int p);  return (p >> 16) & 1; endfunction

    function automatic int p_add(int p, int k, int len);
        int o = p_ofs(p) + k;
        int l = p_lap(p);
        if (len > 0 && o >= len) begin
            o = o - len;
            l = l ^ 1;
        end
        return (l << 16) | o;
    endfunction

    function automatic int m_fill();
        int d = p_ofs(m_wr) - p_ofs(m_rd);
        if (p_lap(m_wr) != p_lap(m_rd)) d = d + int'(cfg_len);
        return d;
    endfunction

    function automatic bit m_empty(); return m_wr == m_rd; endfunction
    function automatic bit m_full();
        return (p_ofs(m_wr) == p_ofs(m_rd)) && (p_lap(m_wr) != p_lap(m_rd));
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        int  f    = m_fill();
        int  r    = int'(cfg_len) - f;
        bit  irq  = cfg_dir ? (r >= int'(cfg_thresh)) : (f >= int'(cfg_thresh));
        chk(int'(rd_ptr_o) == m_rd, "R2 R3 read pointer", int'(rd_ptr_o), m_rd);
        chk(int'(wr_ptr_o) == m_wr, "R2 R3 write pointer", int'(wr_ptr_o), m_wr);
        chk(int'(valid_size) == f, "R4 valid size", int'(valid_size), f);
        chk(int'(left_size) == r, "R5 left size", int'(left_size), r);
        chk(int'(valid_size) + int'(left_size) == int'(cfg_len), "R5 size sum",
            int'(valid_size) + int'(left_size), int'(cfg_len));
        chk(ring_empty == m_empty(), "R6 empty flag", int'(ring_empty), int'(m_empty()));
        chk(ring_full == m_full(), "R6 full flag", int'(ring_full), int'(m_full()));
        chk(thr_irq == irq, "R8 threshold irq", int'(thr_irq), int'(irq));
    endtask

    // Drive one cycle after a falling edge, update model, check at next falling edge.
    task automatic step(bit adv, bit we, int val);
        bit ok;
        hw_adv     = adv;
        sw_ptr_we  = we;
        sw_ptr_val = 17'(val);
        ok = adv && (cfg_len != 0) && !(cfg_dir ? m_empty() : m_full());
        if (we) begin
            if (cfg_dir) m_wr = val; else m_rd = val;
        end
        if (ok) begin
            if (cfg_dir) m_rd = p_add(m_rd, 1, int'(cfg_len));
            else         m_wr = p_add(m_wr, 1, int'(cfg_len));
        end
        @(negedge clk);
        hw_adv    = 1'b0;
        sw_ptr_we = 1'b0;
        check_all();
    endtask

    task automatic start_cfg(int len, int thr, bit dir);
        @(negedge clk);
        rst        = 1'b1;
        cfg_len    = 16'(len);
        cfg_thresh = 16'(thr);
        cfg_dir    = dir;
        @(negedge clk);
        @(negedge clk);
        rst  = 1'b0;
        m_rd = 0;
        m_wr = 0;
        @(negedge clk);
        chk(rd_ptr_o == '0 && wr_ptr_o == '0, "R1 pointers after reset",
            int'(rd_ptr_o) + int'(wr_ptr_o), 0);
        chk(ring_empty && !ring_full && int'(left_size) == len, "R1 flags and left size",
            int'(left_size), len);
        check_all();
    endtask

    task automatic random_run(int ncyc);
        for (int i = 0; i < ncyc; i++) begin
            bit adv = ($urandom_range(0, 1) == 1);
            bit we  = ($urandom_range(0, 3) == 0);
            int val;
            int f   = m_fill();
            int len = int'(cfg_len);
            if (cfg_dir) begin
                val = p_add(m_wr, $urandom_range(0, len - f), len);
            end else if ($urandom_range(0, 1) == 1) begin
                val = m_wr;
            end else begin
                val = p_add(m_rd, $urandom_range(0, f), len);
            end
            step(adv, we, val);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        @(negedge clk);
        chk(ring_empty && rd_ptr_o == '0, "R1 state during reset", int'(rd_ptr_o), 0);

        // One-byte receive ring: every step wraps.
        start_cfg(1, 1, 1'b0);
        step(1'b1, 1'b0, 0);
        chk(int'(wr_ptr_o) == 32'h10000, "R2 lap flip at length", int'(wr_ptr_o), 32'h10000);
        chk(ring_full && thr_irq, "R6 R8 one-byte ring full", int'(ring_full), 1);
        step(1'b1, 1'b0, 0);
        chk(int'(wr_ptr_o) == 32'h10000, "R7 strobe into full receive ring", int'(wr_ptr_o), 32'h10000);
        step(1'b0, 1'b1, m_wr);
        chk(ring_empty && int'(rd_ptr_o) == 32'h10000, "R3 receive release", int'(rd_ptr_o), 32'h10000);

        // Zero length: strobe ignored.
        start_cfg(0, 0, 1'b0);
        step(1'b1, 1'b0, 0);
        chk(wr_ptr_o == '0, "R7 strobe with zero length", int'(wr_ptr_o), 0);

        // Transmit: empty strobe ignored, threshold equal to length.
        start_cfg(8, 8, 1'b1);
        chk(thr_irq == 1'b1, "R8 drained transmit ring requests", int'(thr_irq), 1);
        step(1'b1, 1'b0, 0);
        chk(rd_ptr_o == '0, "R7 strobe into empty transmit ring", int'(rd_ptr_o), 0);
        step(1'b0, 1'b1, 5);
        chk(thr_irq == 1'b0 && int'(valid_size) == 5, "R8 pending data holds request low",
            int'(thr_irq), 0);
        step(1'b1, 1'b1, p_add(m_wr, 3, 8));
        chk(int'(rd_ptr_o) == 1 && int'(wr_ptr_o) == 32'h10000, "R9 load and advance together",
            int'(wr_ptr_o), 32'h10000);
        random_run(3000);

        // Random mixes over several lengths and thresholds.
        start_cfg(5, 4, 1'b0);      random_run(3000);
        start_cfg(12, 9, 1'b1);     random_run(3000);
        start_cfg(100, 75, 1'b0);   random_run(3000);
        start_cfg(65535, 49151, 1'b0); random_run(3000);
        start_cfg(65535, 65535, 1'b1); random_run(3000);
        start_cfg(1, 1, 1'b1);      random_run(1000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule